// File: doc/BRIEF.md
# Watchdog Monitor Timer with Reset Pulse

The block is a watchdog monitor for a small processor system. Software loads a reload value a byte at a time into a set of holding latches, then produces a rising transition on a control bit. That first rising transition wakes the watchdog and copies the latches into a down-counter. Each later rising transition copies the latches in again and restarts the time-out period. A falling transition on the control bit is ignored.

The counter steps down on strobes that mark the falling edge of an external timer clock. There is no prescaler: the lowest byte always counts, and each higher byte decrements when every byte below it is zero. On a strobe that marks the rising edge of the timer clock, a count of zero is a time-out. The block then drives an active-low reset request low for a fixed number of system clock cycles, two by default, and returns to its inert state. The latches keep their contents through that pulse. They are cleared only by the system reset input.

Top module: `wdog_monitor`

## Requirements
- R1: After the system reset input (synchronous, active low) is released, the watchdog is inert. `rst_req_n` stays high and timer strobes have no effect until a rising transition of `ctl_arm` is seen.
- R2: A rising transition of `ctl_arm` arms the watchdog and loads the counter with the latch contents. Byte 0 is the least significant byte. After reload value N, the time-out fires on the first `tck_rise` strobe that follows N `tck_fall` strobes.
- R3: Each later rising transition of `ctl_arm` reloads the counter from the latches, which restarts the full period.
- R4: A falling transition of `ctl_arm` changes neither the count nor the armed state.
- R5: There is no prescaler. Each `tck_fall` strobe takes exactly one from the whole count, so a borrow out of a lower byte decrements the next byte up (for example, 0x0100 needs 256 strobes).
- R6: On time-out `rst_req_n` goes low starting the cycle after the timing `tck_rise` strobe. It stays low for exactly PULSE_CYCLES (default 2) clock cycles and then returns high.
- R7: A time-out disarms the watchdog, and no further pulse occurs without a new rising transition. The latches keep their values, so re-arming without writing them gives the same period.
- R8: The system reset clears the latches to zero and ends a pulse in progress. Arming after it with no latch write times out on the first `tck_rise` strobe.
- R9: When a rising transition of `ctl_arm` and a time-out fall in the same cycle, the reload wins and no pulse is issued.
- R10: The registered copy of `ctl_arm` is cleared by reset. If `ctl_arm` is high in the first cycle after reset, that counts as a rising transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| lat_we | input | NUM_BYTES | Per-byte latch write enable, bit 0 = least significant byte |
| wr_data | input | BYTE_W | Byte written into the enabled latch |
| ctl_arm | input | 1 | Control bit; its rising transition arms and refreshes |
| tck_fall | input | 1 | One-cycle strobe: timer clock falling edge (count step) |
| tck_rise | input | 1 | One-cycle strobe: timer clock rising edge (time-out test) |
| rst_req_n | output | 1 | Active-low reset request pulse |

## Verification
The main count-to-time-out path is driven with reload values chosen to reach different parts of the counter. Small values check the low byte on its own. The values 0x00FF, 0x0100, 0x0101 and 0x01FF separate a correct borrow into the high byte from a missing borrow or a borrow one step early. Each of these runs also drops the control bit partway through, so a block that reacts to falling transitions shows up as a period of the wrong length. Directed sequences cover the remaining cases: refresh in mid-count, refresh in the same cycle as a time-out, re-arming after a time-out (which tells retained latches from cleared ones), an external reset during a pulse, and the control bit held high through reset.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the watchdog monitor.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package wdog_pkg;
    // Operating state of the watchdog counter.
    typedef enum logic [0:0] {
        WD_IDLE = 1'b0,
        WD_RUN  = 1'b1
    } wd_state_e;
endpackage

// File: rtl/wdog_edge.sv
`timescale 1ns/1ps
// Module: wdog_edge
// Detects a rising transition of the control bit.
// Assumes: ctl is synchronous to clk. The registered copy is cleared by
// reset, so a high level in the first cycle after reset is a rising transition.
module wdog_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl,
    output logic rise
);
    logic ctl_q;

    // Keep a one-cycle-old copy of the control bit.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= 1'b0;
        else        ctl_q <= ctl;
    end

    // A rising transition is the bit high now and low in the previous cycle.
    always_comb rise = ctl & ~ctl_q;
endmodule

// File: rtl/wdog_latch.sv
`timescale 1ns/1ps
// Module: wdog_latch
// Holds the reload value, written one byte at a time.
// Assumes: reset clears every byte. Byte 0 is the least significant.
module wdog_latch #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BYTES-1:0]        we,
    input  logic [BYTE_W-1:0]           din,
    output logic [BYTE_W*NUM_BYTES-1:0] value
);
    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;

        // Capture the written byte when this byte's enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n)      byte_q <= '0;
            else if (we[gi]) byte_q <= din;
        end

        assign value[gi*BYTE_W +: BYTE_W] = byte_q;
    end
endmodule

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
// Module: wdog_count
// Arming state and a byte-cascaded down-counter. A reload arms the counter.
// A falling strobe takes one from the count. A rising strobe while the count
// is zero is a time-out, which raises expire for one cycle and disarms.
// Assumes: a reload takes priority over a time-out in the same cycle, and a
// time-out takes priority over a falling strobe in the same cycle.
module wdog_count
    import wdog_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 2,
    localparam int CNT_W    = BYTE_W * NUM_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             step,
    input  logic             test,
    input  logic [CNT_W-1:0] load_val,
    output logic             armed,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    wd_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dec_val;
    logic [NUM_BYTES-1:0] borrow;

    // The least significant byte always takes the borrow.
    assign borrow[0] = 1'b1;

    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_dec
        // Decrement this byte when a borrow reaches it.
        assign dec_val[gi*BYTE_W +: BYTE_W] =
            cnt_q[gi*BYTE_W +: BYTE_W] - {{(BYTE_W-1){1'b0}}, borrow[gi]};
        if (gi < NUM_BYTES - 1) begin : g_chain
            // Pass the borrow up only while this byte is zero.
            assign borrow[gi+1] = borrow[gi] & (cnt_q[gi*BYTE_W +: BYTE_W] == '0);
        end
    end

    // Time-out: armed, count at zero, rising strobe, and no reload.
    always_comb expire = (state_q == WD_RUN) && test && (cnt_q == '0) && !reload;

    // Arming state: a reload arms, a time-out disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= WD_IDLE;
        else if (reload) state_q <= WD_RUN;
        else if (expire) state_q <= WD_IDLE;
    end

    // Count register: reload from the latches or step down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (reload)
            cnt_q <= load_val;
        else if ((state_q == WD_RUN) && step && !expire)
            cnt_q <= dec_val;
    end

    always_comb armed = (state_q == WD_RUN);
    always_comb count = cnt_q;
endmodule

// File: rtl/wdog_pulse.sv
`timescale 1ns/1ps
// Module: wdog_pulse
// Stretches a one-cycle fire request into a low pulse of PULSE_CYCLES cycles.
// Assumes: PULSE_CYCLES >= 1. A fire during a pulse restarts the pulse.
module wdog_pulse #(
    parameter int PULSE_CYCLES = 2,
    localparam int PW          = $clog2(PULSE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic out_n
);
    logic [PW-1:0] left_q;

    // Load the remaining length on fire, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (fire)           left_q <= PW'(PULSE_CYCLES);
        else if (left_q != '0)   left_q <= left_q - PW'(1);
    end

    // The output is low while cycles remain.
    always_comb out_n = (left_q == '0);
endmodule

// File: rtl/wdog_monitor.sv
`timescale 1ns/1ps
// Module: wdog_monitor (top)
// Watchdog monitor: byte reload latches, control-bit edge detector,
// cascaded down-counter and reset-pulse stretcher.
// Assumes: every input is synchronous to clk, and tck_fall and tck_rise are
// one-cycle strobes produced from the timer clock by logic elsewhere.
module wdog_monitor #(
    parameter int BYTE_W       = 8,
    parameter int NUM_BYTES    = 2,
    parameter int PULSE_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] lat_we,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic                 ctl_arm,
    input  logic                 tck_fall,
    input  logic                 tck_rise,
    output logic                 rst_req_n
);
    localparam int CNT_W = BYTE_W * NUM_BYTES;

    logic             refresh;
    logic             armed;
    logic             expire;
    logic [CNT_W-1:0] latch_val;
    logic [CNT_W-1:0] cnt_val;

    wdog_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl_arm),
        .rise  (refresh)
    );

    wdog_latch #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lat_we),
        .din   (wr_data),
        .value (latch_val)
    );

    wdog_count #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (refresh),
        .step     (tck_fall),
        .test     (tck_rise),
        .load_val (latch_val),
        .armed    (armed),
        .count    (cnt_val),
        .expire   (expire)
    );

    wdog_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (expire),
        .out_n (rst_req_n)
    );
endmodule

// File: rtl/wdog_monitor_chk.sv
`timescale 1ns/1ps
// Module: wdog_monitor_chk
// Property checker for wdog_monitor, attached to it by the bind at the end
// of this file.
// Assumes: rst_n is low at time zero.
module wdog_monitor_chk #(
    parameter int BYTE_W       = 8,
    parameter int NUM_BYTES    = 2,
    parameter int PULSE_CYCLES = 2,
    localparam int CNT_W       = BYTE_W * NUM_BYTES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_arm,
    input logic             tck_fall,
    input logic             tck_rise,
    input logic             rst_req_n,
    input logic             armed,
    input logic             refresh,
    input logic             expire,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] latch_val
);
    logic [15:0] low_run;

    // Count consecutive low cycles of the reset request; a new fire restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_req_n || expire) low_run <= '0;
        else                              low_run <= low_run + 16'd1;
    end

    // R6: the pulse is never longer than PULSE_CYCLES cycles.
    always_ff @(posedge clk) begin
        if (rst_n && !rst_req_n)
            a_r6_pulse_max: assert (low_run < 16'(PULSE_CYCLES));
    end

    if (PULSE_CYCLES > 1) begin : g_min
        a_r6_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rst_req_n) |=> !rst_req_n);
    end

    a_r1_pulse_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_n) |-> $past(armed));

    a_r2_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (armed && cnt == $past(latch_val)));

    a_r4_fall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_arm) && !ctl_arm && armed && !tck_fall && !tck_rise)
        |=> (armed && $stable(cnt)));

    a_r7_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_n) |-> !armed);

    a_r9_refresh_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && rst_req_n) |=> rst_req_n);
endmodule

bind wdog_monitor wdog_monitor_chk #(
    .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .PULSE_CYCLES(PULSE_CYCLES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_arm   (ctl_arm),
    .tck_fall  (tck_fall),
    .tck_rise  (tck_rise),
    .rst_req_n (rst_req_n),
    .armed     (armed),
    .refresh   (refresh),
    .expire    (expire),
    .cnt       (cnt_val),
    .latch_val (latch_val)
);

// File: tb/wdog_monitor_tb_top.sv
`timescale 1ns/1ps
module wdog_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lat_we = '0;
    logic [7:0] wr_data = '0;
    logic       ctl_arm = 1'b0;
    logic       tck_fall = 1'b0;
    logic       tck_rise = 1'b0;
    logic       rst_req_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reload value in the upper half, expected falling strobes before the pulse in the lower half.
    localparam logic [31:0] VEC [7] = '{
        {16'h0003, 16'd3}, {16'h0001, 16'd1}, {16'h0010, 16'd16},
        {16'h00FF, 16'd255}, {16'h0100, 16'd256}, {16'h0101, 16'd257},
        {16'h01FF, 16'd511}
    };

    always #2.5 clk = ~clk;

    wdog_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .lat_we(lat_we), .wr_data(wr_data),
        .ctl_arm(ctl_arm), .tck_fall(tck_fall), .tck_rise(tck_rise),
        .rst_req_n(rst_req_n)
    );

    task automatic check(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: inputs already set are taken at the posedge, outputs read at the negedge.
    task automatic step(input bit f, input bit r);
        tck_fall = f;
        tck_rise = r;
        @(negedge clk);
        tck_fall = 1'b0;
        tck_rise = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        lat_we = 2'b01; wr_data = v[7:0];  step(0, 0);
        lat_we = 2'b10; wr_data = v[15:8]; step(0, 0);
        lat_we = 2'b00;
    endtask

    task automatic arm();
        ctl_arm = 1'b0; step(0, 0);
        ctl_arm = 1'b1; step(0, 0);
    endtask

    // Falling strobes counted before the pulse appears; -1 if it never appears.
    task automatic measure(input int maxn, output int n);
        n = -1;
        for (int k = 0; k <= maxn + 2; k++) begin
            step(0, 1);
            if (!rst_req_n) begin n = k; return; end
            step(1, 0);
        end
    endtask

    // First low cycle seen already: one more low cycle, then high.
    task automatic check_width(input string req);
        check(rst_req_n, 0, req);
        step(0, 0); check(rst_req_n, 0, req);
        step(0, 0); check(rst_req_n, 1, req);
    endtask

    task automatic reset_cycle();
        rst_n = 1'b0; step(0, 0); step(0, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int lows;
        @(negedge clk);
        reset_cycle();
        // R1: reset state and strobes with no arming.
        check(rst_req_n, 1, "R1 reset state");
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            step(1, 0); lows += !rst_req_n;
            step(0, 1); lows += !rst_req_n;
        end
        check(lows, 0, "R1 inert before arming");

        // R10: control bit held high through reset is a rising transition.
        ctl_arm = 1'b1;
        rst_n = 1'b0; step(0, 0); step(0, 0);
        rst_n = 1'b1; step(0, 0);
        measure(2, n);
        check(n, 0, "R10 high after reset arms");
        check_width("R6 pulse after R10");

        // R2 R4 R5 R6: vector table; control drops mid-run.
        foreach (VEC[i]) begin
            load(VEC[i][31:16]);
            arm();
            ctl_arm = 1'b0; step(0, 0);
            measure(int'(VEC[i][15:0]), n);
            check(n, int'(VEC[i][15:0]), "R2/R4/R5 period");
            check_width("R6 pulse width");
        end

        // R3: refresh in mid-count restarts the full period.
        load(16'd6); arm();
        for (int i = 0; i < 4; i++) step(1, 0);
        arm();
        measure(10, n);
        check(n, 6, "R3 refresh restarts");
        check_width("R6 after R3");

        // R9: refresh and time-out in the same cycle.
        load(16'd1); arm();
        step(1, 0);
        ctl_arm = 1'b0; step(0, 0);
        ctl_arm = 1'b1; step(0, 1);
        check(rst_req_n, 1, "R9 refresh wins");
        step(0, 0);
        check(rst_req_n, 1, "R9 no late pulse");
        measure(4, n);
        check(n, 1, "R9 period reloaded");
        check_width("R6 after R9");

        // R7: disarmed after time-out; latches kept.
        load(16'd2); arm();
        measure(4, n);
        check(n, 2, "R7 first period");
        check_width("R6 after R7");
        lows = 0;
        for (int i = 0; i < 6; i++) begin
            step(1, 0); lows += !rst_req_n;
            step(0, 1); lows += !rst_req_n;
        end
        check(lows, 0, "R7 no pulse while disarmed");
        arm();
        measure(4, n);
        check(n, 2, "R7 latches kept");
        check_width("R6 after R7 rearm");

        // R8: external reset cancels the pulse and clears the latches.
        load(16'd3); arm();
        measure(5, n);
        check(n, 3, "R8 setup period");
        reset_cycle();
        check(rst_req_n, 1, "R8 pulse cancelled");
        step(0, 0);
        check(rst_req_n, 1, "R8 stays high");
        arm();
        measure(2, n);
        check(n, 0, "R8 latches cleared");
        check_width("R6 after R8");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule